// File: doc/BRIEF.md
# Home directory coherence controller

This block is the home side of a directory-based coherence scheme for a small group of private caches (four by default). For every address it holds a directory entry and the home copy of the data word. Caches reach it through two input queue heads. A low-priority head carries read-share and read-exclusive requests. A high-priority head carries invalidate acknowledgements, writeback replies and flush replies. The block answers on one message output, which sends share and exclusive grants with data, invalidate requests to a set of caches, and writeback or flush requests to the current owner.

Each entry is in one of four states: shared with a sharer vector, owned by one cache, waiting for invalidate acknowledgements with a pending sharer vector, or waiting for the owner's writeback or flush. A request that must first recall copies moves the entry into a waiting state and stays at the head of its queue. It is not dequeued. The block evaluates it again once the replies have returned the entry to a stable state, and only then grants it. Replies always win over requests in the same cycle, so a stalled request can never block the replies it is waiting on.

Top module: `coh_home_dir`

## Requirements
- R1: After reset every entry is shared with an empty sharer vector and holds data zero. With no input valid, both dequeue outputs and `msg_valid` stay low.
- R2: While `hi_valid` is high, `hi_deq` is high in the same cycle and `lo_deq` is low, whatever the request head holds.
- R3: A share request (`lo_excl`=0) to a shared entry is dequeued. The requester's bit is added to the sharer vector (it may already be set), and a share grant (`msg_kind`=0) with the stored data goes to the requester alone.
- R4: A share request to an entry owned by a different cache is not dequeued. The entry moves to the owner-recall state, and a writeback request (`msg_kind`=3) goes to the owner alone.
- R5: An exclusive request (`lo_excl`=1) to a shared entry with no sharer other than the requester is dequeued. The requester becomes owner, and an exclusive grant (`msg_kind`=1) with the stored data goes to the requester.
- R6: An exclusive request to a shared entry with other sharers is not dequeued. The entry moves to the invalidate-wait state holding those other sharers, and one invalidate request (`msg_kind`=2) goes to exactly that set. The requester's bit is never set in `msg_dest`.
- R7: An exclusive request to an entry owned by a different cache is not dequeued. The entry moves to the owner-recall state, and a flush request (`msg_kind`=4) goes to the owner.
- R8: Any request from the cache that already owns the entry is dequeued and answered with an exclusive grant carrying the stored data. The entry is left unchanged.
- R9: A request to an entry in the invalidate-wait state with a non-empty pending vector, or in the owner-recall state, is not dequeued and produces no message. The same head is evaluated again on later cycles.
- R10: An invalidate acknowledgement (`hi_kind`=0) clears the sender's bit in the shared or invalidate-wait state. An invalidate-wait entry whose vector becomes empty becomes shared. In the owned or owner-recall state the acknowledgement is dequeued and ignored.
- R11: A writeback reply (`hi_kind`=1) stores `hi_data` and leaves the entry shared by the sender only. A flush reply (`hi_kind`=2) stores `hi_data` and leaves the entry shared with an empty vector. Code 3 is dequeued with no effect.
- R12: A message appears on the output in the cycle after the clock edge that processed its request, and lasts exactly one cycle. `msg_data` is zero on all messages except grants. Reply cycles and idle cycles emit nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_valid | input | 1 | Request queue head is valid |
| lo_excl | input | 1 | 0 share request, 1 exclusive request |
| lo_src | input | 2 | Requesting cache id |
| lo_addr | input | 4 | Request address |
| lo_deq | output | 1 | Request head consumed this cycle |
| hi_valid | input | 1 | Reply queue head is valid |
| hi_kind | input | 2 | 0 invalidate ack, 1 writeback, 2 flush, 3 none |
| hi_src | input | 2 | Replying cache id |
| hi_addr | input | 4 | Reply address |
| hi_data | input | 32 | Data carried by writeback or flush |
| hi_deq | output | 1 | Reply head consumed this cycle |
| msg_valid | output | 1 | Outgoing message valid (one cycle) |
| msg_kind | output | 3 | 0 share grant, 1 exclusive grant, 2 invalidate, 3 writeback request, 4 flush request |
| msg_dest | output | 4 | Destination cache mask |
| msg_addr | output | 4 | Message address |
| msg_data | output | 32 | Grant data, zero otherwise |

## Verification
Several properties are checked on every cycle: replies take priority over requests, every dequeued request produces a grant on the next cycle, reply and idle cycles stay silent, non-invalidate messages have a single target, and an invalidate never reaches its own requester. Other behaviour cannot be seen in one cycle and only the bench scenarios show it: the sharer vector shrinking as acknowledgements arrive, a stalled request being granted once its entry settles, and writeback or flush data coming back in a later grant. A per-address reference model, driven with directed sequences and seeded random traffic on a few colliding addresses, covers these.

// File: rtl/coh_pkg.sv
package coh_pkg;

    typedef enum logic [1:0] {
        ST_SHARED   = 2'd0,
        ST_OWNED    = 2'd1,
        ST_INV_WAIT = 2'd2,
        ST_RECALL   = 2'd3
    } dir_state_e;

    typedef enum logic [1:0] {
        REP_INV_ACK = 2'd0,
        REP_WB      = 2'd1,
        REP_FLUSH   = 2'd2,
        REP_NONE    = 2'd3
    } rep_kind_e;

    typedef enum logic [2:0] {
        MSG_SH_GRANT = 3'd0,
        MSG_EX_GRANT = 3'd1,
        MSG_INV      = 3'd2,
        MSG_WB_REQ   = 3'd3,
        MSG_FL_REQ   = 3'd4
    } msg_kind_e;

endpackage

// File: rtl/coh_dir_array.sv
module coh_dir_array
    import coh_pkg::*;
#(
    parameter int N       = 4,
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 32,
    localparam int SRC_W  = $clog2(N),
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] a_addr,
    output dir_state_e        a_state,
    output logic [N-1:0]      a_set,
    output logic [SRC_W-1:0]  a_own,
    output logic [DATA_W-1:0] a_data,
    input  logic [ADDR_W-1:0] b_addr,
    output dir_state_e        b_state,
    output logic [N-1:0]      b_set,
    input  logic              wr_en,
    input  logic              wr_data_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  dir_state_e        wr_state,
    input  logic [N-1:0]      wr_set,
    input  logic [SRC_W-1:0]  wr_own,
    input  logic [DATA_W-1:0] wr_data
);

    typedef struct packed {
        dir_state_e        st;
        logic [N-1:0]      set;
        logic [SRC_W-1:0]  own;
        logic [DATA_W-1:0] data;
    } entry_t;

    entry_t ent_q [ENTRIES];
    entry_t ent_d [ENTRIES];

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_addr].st  = wr_state;
            ent_d[wr_addr].set = wr_set;
            ent_d[wr_addr].own = wr_own;
        end
        if (wr_data_en) begin
            ent_d[wr_addr].data = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < ENTRIES; i++) begin
            if (!rst_n) begin
                ent_q[i] <= '{st: ST_SHARED, set: '0, own: '0, data: '0};
            end else begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    assign a_state = ent_q[a_addr].st;
    assign a_set   = ent_q[a_addr].set;
    assign a_own   = ent_q[a_addr].own;
    assign a_data  = ent_q[a_addr].data;
    assign b_state = ent_q[b_addr].st;
    assign b_set   = ent_q[b_addr].set;

endmodule

// File: rtl/coh_req_eval.sv
module coh_req_eval
    import coh_pkg::*;
#(
    parameter int N      = 4,
    parameter int DATA_W = 32,
    localparam int SRC_W = $clog2(N)
) (
    input  logic              excl,
    input  logic [SRC_W-1:0]  src,
    input  dir_state_e        e_state,
    input  logic [N-1:0]      e_set,
    input  logic [SRC_W-1:0]  e_own,
    input  logic [DATA_W-1:0] e_data,
    output logic              deq,
    output logic              upd,
    output dir_state_e        n_state,
    output logic [N-1:0]      n_set,
    output logic [SRC_W-1:0]  n_own,
    output logic              m_valid,
    output msg_kind_e         m_kind,
    output logic [N-1:0]      m_dest,
    output logic [DATA_W-1:0] m_data
);

    logic [N-1:0] src_bit;
    logic [N-1:0] own_bit;
    logic [N-1:0] others;
    logic         stable_shared;

    assign src_bit = N'(1) << src;
    assign own_bit = N'(1) << e_own;
    assign others  = e_set & ~src_bit;
    // an invalidate-wait entry with nothing pending behaves as shared
    assign stable_shared = (e_state == ST_SHARED) ||
                           ((e_state == ST_INV_WAIT) && (e_set == '0));

    always_comb begin
        deq     = 1'b0;
        upd     = 1'b0;
        n_state = e_state;
        n_set   = e_set;
        n_own   = e_own;
        m_valid = 1'b0;
        m_kind  = MSG_SH_GRANT;
        m_dest  = '0;
        m_data  = '0;
        if (stable_shared) begin
            if (!excl) begin
                deq     = 1'b1;
                upd     = 1'b1;
                n_state = ST_SHARED;
                n_set   = e_set | src_bit;
                m_valid = 1'b1;
                m_kind  = MSG_SH_GRANT;
                m_dest  = src_bit;
                m_data  = e_data;
            end else if (others == '0) begin
                deq     = 1'b1;
                upd     = 1'b1;
                n_state = ST_OWNED;
                n_set   = '0;
                n_own   = src;
                m_valid = 1'b1;
                m_kind  = MSG_EX_GRANT;
                m_dest  = src_bit;
                m_data  = e_data;
            end else begin
                upd     = 1'b1;
                n_state = ST_INV_WAIT;
                n_set   = others;
                m_valid = 1'b1;
                m_kind  = MSG_INV;
                m_dest  = others;
            end
        end else if (e_state == ST_OWNED) begin
            if (e_own == src) begin
                deq     = 1'b1;
                m_valid = 1'b1;
                m_kind  = MSG_EX_GRANT;
                m_dest  = src_bit;
                m_data  = e_data;
            end else begin
                upd     = 1'b1;
                n_state = ST_RECALL;
                m_valid = 1'b1;
                m_kind  = excl ? MSG_FL_REQ : MSG_WB_REQ;
                m_dest  = own_bit;
            end
        end
        // invalidate-wait with pending sharers, or owner recall: stall
    end

endmodule

// File: rtl/coh_rep_eval.sv
module coh_rep_eval
    import coh_pkg::*;
#(
    parameter int N      = 4,
    localparam int SRC_W = $clog2(N)
) (
    input  rep_kind_e         kind,
    input  logic [SRC_W-1:0]  src,
    input  dir_state_e        e_state,
    input  logic [N-1:0]      e_set,
    output logic              upd,
    output logic              data_we,
    output dir_state_e        n_state,
    output logic [N-1:0]      n_set,
    output logic [SRC_W-1:0]  n_own
);

    logic [N-1:0] src_bit;
    logic [N-1:0] cleared;

    assign src_bit = N'(1) << src;
    assign cleared = e_set & ~src_bit;

    always_comb begin
        upd     = 1'b0;
        data_we = 1'b0;
        n_state = e_state;
        n_set   = e_set;
        n_own   = '0;
        unique case (kind)
            REP_INV_ACK: begin
                if (e_state == ST_SHARED || e_state == ST_INV_WAIT) begin
                    upd     = 1'b1;
                    n_set   = cleared;
                    n_state = (cleared == '0) ? ST_SHARED : e_state;
                end
            end
            REP_WB: begin
                upd     = 1'b1;
                data_we = 1'b1;
                n_state = ST_SHARED;
                n_set   = src_bit;
            end
            REP_FLUSH: begin
                upd     = 1'b1;
                data_we = 1'b1;
                n_state = ST_SHARED;
                n_set   = '0;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/coh_home_dir.sv
module coh_home_dir
    import coh_pkg::*;
#(
    parameter int N       = 4,
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 32,
    localparam int SRC_W  = $clog2(N),
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_valid,
    input  logic              lo_excl,
    input  logic [SRC_W-1:0]  lo_src,
    input  logic [ADDR_W-1:0] lo_addr,
    output logic              lo_deq,
    input  logic              hi_valid,
    input  logic [1:0]        hi_kind,
    input  logic [SRC_W-1:0]  hi_src,
    input  logic [ADDR_W-1:0] hi_addr,
    input  logic [DATA_W-1:0] hi_data,
    output logic              hi_deq,
    output logic              msg_valid,
    output logic [2:0]        msg_kind,
    output logic [N-1:0]      msg_dest,
    output logic [ADDR_W-1:0] msg_addr,
    output logic [DATA_W-1:0] msg_data
);

    typedef struct packed {
        logic              valid;
        msg_kind_e         kind;
        logic [N-1:0]      dest;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } out_msg_t;

    out_msg_t out_d, out_q;

    dir_state_e        a_state, b_state;
    logic [N-1:0]      a_set, b_set;
    logic [SRC_W-1:0]  a_own;
    logic [DATA_W-1:0] a_data;

    logic              rq_deq, rq_upd, rq_mv;
    dir_state_e        rq_state;
    logic [N-1:0]      rq_set, rq_dest;
    logic [SRC_W-1:0]  rq_own;
    msg_kind_e         rq_kind;
    logic [DATA_W-1:0] rq_data;

    logic              rp_upd, rp_we;
    dir_state_e        rp_state;
    logic [N-1:0]      rp_set;
    logic [SRC_W-1:0]  rp_own;

    logic              take_rep, take_req;
    logic              wr_en, wr_data_en;
    logic [ADDR_W-1:0] wr_addr;
    dir_state_e        wr_state;
    logic [N-1:0]      wr_set;
    logic [SRC_W-1:0]  wr_own;

    coh_dir_array #(.N(N), .ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .a_addr     (lo_addr),
        .a_state    (a_state),
        .a_set      (a_set),
        .a_own      (a_own),
        .a_data     (a_data),
        .b_addr     (hi_addr),
        .b_state    (b_state),
        .b_set      (b_set),
        .wr_en      (wr_en),
        .wr_data_en (wr_data_en),
        .wr_addr    (wr_addr),
        .wr_state   (wr_state),
        .wr_set     (wr_set),
        .wr_own     (wr_own),
        .wr_data    (hi_data)
    );

    coh_req_eval #(.N(N), .DATA_W(DATA_W)) u_req (
        .excl    (lo_excl),
        .src     (lo_src),
        .e_state (a_state),
        .e_set   (a_set),
        .e_own   (a_own),
        .e_data  (a_data),
        .deq     (rq_deq),
        .upd     (rq_upd),
        .n_state (rq_state),
        .n_set   (rq_set),
        .n_own   (rq_own),
        .m_valid (rq_mv),
        .m_kind  (rq_kind),
        .m_dest  (rq_dest),
        .m_data  (rq_data)
    );

    coh_rep_eval #(.N(N)) u_rep (
        .kind    (rep_kind_e'(hi_kind)),
        .src     (hi_src),
        .e_state (b_state),
        .e_set   (b_set),
        .upd     (rp_upd),
        .data_we (rp_we),
        .n_state (rp_state),
        .n_set   (rp_set),
        .n_own   (rp_own)
    );

    // replies always win; a request is looked at only on reply-free cycles
    assign take_rep = hi_valid;
    assign take_req = lo_valid && !hi_valid;

    always_comb begin
        wr_en      = 1'b0;
        wr_data_en = 1'b0;
        wr_addr    = lo_addr;
        wr_state   = rq_state;
        wr_set     = rq_set;
        wr_own     = rq_own;
        if (take_rep) begin
            wr_en      = rp_upd;
            wr_data_en = rp_we;
            wr_addr    = hi_addr;
            wr_state   = rp_state;
            wr_set     = rp_set;
            wr_own     = rp_own;
        end else if (take_req) begin
            wr_en = rq_upd;
        end
    end

    always_comb begin
        out_d = '{valid: 1'b0, kind: MSG_SH_GRANT, dest: '0, addr: '0, data: '0};
        if (take_req && rq_mv) begin
            out_d.valid = 1'b1;
            out_d.kind  = rq_kind;
            out_d.dest  = rq_dest;
            out_d.addr  = lo_addr;
            out_d.data  = rq_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '{valid: 1'b0, kind: MSG_SH_GRANT, dest: '0, addr: '0, data: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign hi_deq    = take_rep;
    assign lo_deq    = take_req && rq_deq;
    assign msg_valid = out_q.valid;
    assign msg_kind  = out_q.kind;
    assign msg_dest  = out_q.dest;
    assign msg_addr  = out_q.addr;
    assign msg_data  = out_q.data;

endmodule

// File: rtl/coh_home_dir_chk.sv
module coh_home_dir_chk #(
    parameter int N       = 4,
    parameter int ENTRIES = 16,
    parameter int DATA_W  = 32,
    localparam int SRC_W  = $clog2(N),
    localparam int ADDR_W = $clog2(ENTRIES)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lo_valid,
    input logic [SRC_W-1:0]  lo_src,
    input logic              lo_deq,
    input logic              hi_valid,
    input logic              hi_deq,
    input logic              msg_valid,
    input logic [2:0]        msg_kind,
    input logic [N-1:0]      msg_dest
);

    assert_reply_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> (hi_deq && !lo_deq));

    // a consumed request always yields a grant (R3, R5, R8)
    assert_deq_grants_R3: assert property (@(posedge clk) disable iff (!rst_n)
        lo_deq |=> (msg_valid && (msg_kind == 3'd0 || msg_kind == 3'd1)));

    assert_single_target_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind != 3'd2) |-> ($countones(msg_dest) == 1));

    assert_inv_skips_requester_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && msg_kind == 3'd2) |->
            ((msg_dest != '0) && (((msg_dest >> $past(lo_src)) & N'(1)) == '0)));

    // a held request may only send a recall message, never a grant
    assert_held_no_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_valid && !hi_valid && !lo_deq) |=>
            (!msg_valid || msg_kind == 3'd2 || msg_kind == 3'd3 || msg_kind == 3'd4));

    assert_reply_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |=> !msg_valid);

    assert_idle_silent_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (!lo_valid && !hi_valid) |=> !msg_valid);

endmodule

bind coh_home_dir coh_home_dir_chk #(.N(N), .ENTRIES(ENTRIES), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lo_valid  (lo_valid),
    .lo_src    (lo_src),
    .lo_deq    (lo_deq),
    .hi_valid  (hi_valid),
    .hi_deq    (hi_deq),
    .msg_valid (msg_valid),
    .msg_kind  (msg_kind),
    .msg_dest  (msg_dest)
);

// File: tb/coh_home_dir_bench.sv
`timescale 1ns/1ps
module coh_home_dir_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lo_valid = 1'b0, lo_excl = 1'b0;
    logic [1:0]  lo_src = '0;
    logic [3:0]  lo_addr = '0;
    logic        lo_deq;
    logic        hi_valid = 1'b0;
    logic [1:0]  hi_kind = '0, hi_src = '0;
    logic [3:0]  hi_addr = '0;
    logic [31:0] hi_data = '0;
    logic        hi_deq;
    logic        msg_valid;
    logic [2:0]  msg_kind;
    logic [3:0]  msg_dest, msg_addr;
    logic [31:0] msg_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    coh_home_dir u_coh_home_dir (.*);

    // reference directory: 0 shared, 1 owned, 2 invalidate wait, 3 recall
    int         m_st   [16];
    logic [3:0] m_set  [16];
    logic [1:0] m_own  [16];
    logic [31:0] m_dat [16];

    logic        e_lo, e_hi, e_mv;
    logic [2:0]  e_mk;
    logic [3:0]  e_md, e_ma;
    logic [31:0] e_mdat;
    string       rule;

    function automatic void model_step();
        logic [3:0] sb, oth;
        e_lo = 0; e_hi = 0; e_mv = 0; e_mk = 0; e_md = 0; e_ma = 0; e_mdat = 0;
        rule = "R12";
        if (hi_valid) begin
            e_hi = 1;
            sb = 4'b1 << hi_src;
            rule = "R2";
            if (hi_kind == 0) begin
                rule = "R10";
                if (m_st[hi_addr] == 0 || m_st[hi_addr] == 2) begin
                    m_set[hi_addr] = m_set[hi_addr] & ~sb;
                    if (m_set[hi_addr] == 0) m_st[hi_addr] = 0;
                end
            end else if (hi_kind == 1) begin
                rule = "R11";
                m_st[hi_addr] = 0; m_set[hi_addr] = sb; m_dat[hi_addr] = hi_data;
            end else if (hi_kind == 2) begin
                rule = "R11";
                m_st[hi_addr] = 0; m_set[hi_addr] = 0; m_dat[hi_addr] = hi_data;
            end else begin
                rule = "R11";
            end
        end else if (lo_valid) begin
            sb  = 4'b1 << lo_src;
            oth = m_set[lo_addr] & ~sb;
            e_ma = lo_addr;
            if (m_st[lo_addr] == 0 || (m_st[lo_addr] == 2 && m_set[lo_addr] == 0)) begin
                if (!lo_excl) begin
                    rule = "R3";
                    e_lo = 1; e_mv = 1; e_mk = 0; e_md = sb; e_mdat = m_dat[lo_addr];
                    m_st[lo_addr] = 0; m_set[lo_addr] = m_set[lo_addr] | sb;
                end else if (oth == 0) begin
                    rule = "R5";
                    e_lo = 1; e_mv = 1; e_mk = 1; e_md = sb; e_mdat = m_dat[lo_addr];
                    m_st[lo_addr] = 1; m_set[lo_addr] = 0; m_own[lo_addr] = lo_src;
                end else begin
                    rule = "R6";
                    e_mv = 1; e_mk = 2; e_md = oth;
                    m_st[lo_addr] = 2; m_set[lo_addr] = oth;
                end
            end else if (m_st[lo_addr] == 1) begin
                if (m_own[lo_addr] == lo_src) begin
                    rule = "R8";
                    e_lo = 1; e_mv = 1; e_mk = 1; e_md = sb; e_mdat = m_dat[lo_addr];
                end else begin
                    rule = lo_excl ? "R7" : "R4";
                    e_mv = 1; e_mk = lo_excl ? 3'd4 : 3'd3;
                    e_md = 4'b1 << m_own[lo_addr];
                    m_st[lo_addr] = 3;
                end
            end else begin
                rule = "R9";
            end
        end
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic step(bit lv, bit lx, logic [1:0] ls, logic [3:0] la,
                        bit hv, logic [1:0] hk, logic [1:0] hs, logic [3:0] ha,
                        logic [31:0] hd);
        @(negedge clk);
        lo_valid = lv; lo_excl = lx; lo_src = ls; lo_addr = la;
        hi_valid = hv; hi_kind = hk; hi_src = hs; hi_addr = ha; hi_data = hd;
        #1;
        model_step();
        chk(rule, "lo_deq", 32'(lo_deq), 32'(e_lo));
        chk(rule, "hi_deq", 32'(hi_deq), 32'(e_hi));
        @(posedge clk);
        #1;
        chk(rule, "msg_valid", 32'(msg_valid), 32'(e_mv));
        if (e_mv) begin
            chk(rule, "msg_kind", 32'(msg_kind), 32'(e_mk));
            chk(rule, "msg_dest", 32'(msg_dest), 32'(e_md));
            chk(rule, "msg_addr", 32'(msg_addr), 32'(e_ma));
            chk(rule, "msg_data", msg_data, e_mdat);
        end
    endtask

    task automatic req(bit x, logic [1:0] s, logic [3:0] a);
        step(1, x, s, a, 0, 0, 0, 0, 0);
    endtask

    task automatic rep(logic [1:0] k, logic [1:0] s, logic [3:0] a, logic [31:0] d);
        step(0, 0, 0, 0, 1, k, s, a, d);
    endtask

    initial begin
        int unsigned seed;
        for (int i = 0; i < 16; i++) begin
            m_st[i] = 0; m_set[i] = 0; m_own[i] = 0; m_dat[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "msg_valid in reset", 32'(msg_valid), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "lo_deq idle", 32'(lo_deq), 0);
        chk("R1", "hi_deq idle", 32'(hi_deq), 0);
        chk("R1", "msg_valid idle", 32'(msg_valid), 0);

        req(0, 0, 5);                    // R3 grant, data zero (R1)
        req(0, 2, 5);                    // R3 second sharer
        req(0, 2, 5);                    // R3 already a sharer
        req(1, 1, 5);                    // R6 invalidate {0,2}
        req(1, 1, 5);                    // R9 stalled
        step(1, 1, 1, 5, 1, 0, 0, 5, 0); // R2 reply wins, R10 clears c0
        req(1, 1, 5);                    // R9 still pending c2
        rep(0, 2, 5, 0);                 // R10 wait set drains
        req(1, 1, 5);                    // R5 exclusive grant
        step(0, 0, 0, 0, 0, 0, 0, 0, 0); // R12 pulse ended
        req(1, 1, 5);                    // R8 owner re-request
        req(0, 1, 5);                    // R8 owner share request
        rep(0, 3, 5, 0);                 // R10 ignored while owned
        req(0, 3, 5);                    // R4 writeback request
        req(0, 3, 5);                    // R9 recall stall
        rep(1, 1, 5, 32'hA5A5_0F0F);     // R11 writeback data
        req(0, 3, 5);                    // R3 grant new data
        req(1, 3, 5);                    // R6 invalidate c1 only
        rep(0, 1, 5, 0);                 // R10
        req(1, 3, 5);                    // R5 only requester
        req(1, 0, 5);                    // R7 flush request
        rep(2, 3, 5, 32'h0000_1234);     // R11 flush data
        req(1, 0, 5);                    // R5 with flushed data
        rep(3, 2, 5, 32'hFFFF_FFFF);     // R11 no-op code
        req(0, 0, 5);                    // R8 confirms code 3 changed nothing
        req(0, 1, 9);                    // R3 untouched address reads zero

        seed = 32'd1357;
        void'($urandom(seed));
        for (int i = 0; i < 4000; i++) begin
            bit lv, hv;
            lv = ($urandom % 100) < 70;
            hv = ($urandom % 100) < 35;
            step(lv, 1'($urandom), 2'($urandom), 4'($urandom % 4),
                 hv, 2'($urandom), 2'($urandom), 4'($urandom % 4), $urandom);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule